// File: doc/BRIEF.md
# Blocking Counting Semaphore Cell

This block is a single semaphore cell for inter-thread synchronisation. It holds a 16-bit count. Threads reach it through four access views, and the view is chosen per request. A read in a wait view performs a P operation: it returns the count and decrements it when the count is positive. A write in a signal view performs a V operation: it increments the count, stopping at the maximum value. The write data is ignored.

A wait in the blocking view that finds the count at zero raises `block_o` and records the requesting thread's bit in a wait set. The thread scheduler outside the cell then parks that thread. Any signal that finds a non-empty wait set pulses `wake_o` with the recorded mask and empties the set. The bypass view lets software observe the count without side effects. The control view returns a status tag. The cell has one read port and one write port. When both request in the same cycle, the signal is applied first, and the wait sees the incremented count.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, the wait set is empty, and `rd_valid_o`, `block_o`, `wake_o` and `wake_mask_o` are 0.
- R2: A read request with view 2'b10 (blocking) or 2'b11 (try) gets `rd_valid_o`=1 one cycle later, with `rd_data_o` equal to the count before any decrement, zero-extended.
- R3: A wait read decrements the count by one when the count is greater than zero and leaves it unchanged when the count is zero.
- R4: A wait read in view 2'b10 on a zero count returns 0, raises `block_o` in the response cycle, and sets bit `rd_thread_i` of the wait set. In view 2'b11 it returns 0, and neither raises `block_o` nor records the thread.
- R5: A write with view 2'b10 or 2'b11 increments the count when it is below 0xFFFF and leaves it at 0xFFFF otherwise. `wr_data_i` has no effect.
- R6: A signal write that finds the wait set non-empty gives `wake_o`=1 for one cycle, one cycle later, with `wake_mask_o` equal to the set, and empties the set. With an empty set, `wake_o` stays 0 and `wake_mask_o` stays 0.
- R7: Signal writes in view 2'b10 and in view 2'b11 behave identically.
- R8: A read with view 2'b00 (bypass) returns the count without changing it. Writes with view 2'b00 or 2'b01 change neither the count nor the wait set.
- R9: A read with view 2'b01 (control) returns a tag. Bit 0 of the tag is 1 when the count is zero, and every other bit is 0. The read changes nothing.
- R10: A wait and a signal in the same cycle are applied signal first. The wait returns, and decrements from, the incremented count, and it cannot block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Read request |
| rd_view_i | input | 2 | Read view: 00 bypass, 01 control, 10 blocking wait, 11 try wait |
| rd_thread_i | input | THR_W | Requesting thread index |
| wr_req_i | input | 1 | Write request |
| wr_view_i | input | 2 | Write view: 00 bypass, 01 control, 10 blocking signal, 11 try signal |
| wr_data_i | input | DATA_W | Write data (ignored) |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | DATA_W | Read response data |
| block_o | output | 1 | Requesting thread must block |
| wake_o | output | 1 | Wake pulse |
| wake_mask_o | output | N_THR | Threads to wake |

## Verification
The wait reads are tried on positive, zero and saturated counts, in both forms. This separates a correct decrement and blocking decision from off-by-one or wrap errors. Blocked sets built from several threads, followed by signals in each form, separate a correct wake mask and clear from a stale or merged mask. Bypass and control writes carrying nonzero data, followed by bypass and control reads, show the discarded paths leave no trace. Same-cycle wait and signal pairs on a zero count distinguish signal-first ordering from wait-first ordering. A long random mix is compared every cycle against a behavioural model.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    VIEW_BYP = 2'b00,
    VIEW_CTL = 2'b01,
    VIEW_BLK = 2'b10,
    VIEW_TRY = 2'b11
  } view_e;

  localparam int unsigned TAG_EMPTY_BIT = 0;
endpackage

// File: rtl/sem_count_unit.sv
module sem_count_unit #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sig_i,
  input  logic             wait_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_mid_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_d;
  logic             take;

  // signal is serialized ahead of a same-cycle wait
  always_comb begin
    cnt_mid = cnt_q;
    if (sig_i && (cnt_q != CNT_MAX)) cnt_mid = cnt_q + 1'b1;
    take  = wait_i && (cnt_mid != '0);
    cnt_d = take ? cnt_mid - 1'b1 : cnt_mid;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_mid_o = cnt_mid;

  // R5
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && sig_i && !wait_i) |=> cnt_q == CNT_MAX);

  // R3
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !sig_i) |=> cnt_q == '0);

  // R3
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && wait_i && !sig_i) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/sem_wait_set.sv
module sem_wait_set #(
  parameter int unsigned N_THR = 8,
  parameter int unsigned THR_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sig_i,
  input  logic             blk_set_i,
  input  logic [THR_W-1:0] thread_i,
  output logic             wake_o,
  output logic [N_THR-1:0] wake_mask_o
);
  logic [N_THR-1:0] mask_q;
  logic             wake_q;
  logic [N_THR-1:0] wake_mask_q;

  for (genvar i = 0; i < N_THR; i++) begin : g_bit
    logic hit;
    assign hit = blk_set_i && (thread_i == THR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    mask_q[i] <= 1'b0;
      else if (sig_i) mask_q[i] <= 1'b0;
      else if (hit)   mask_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_q      <= 1'b0;
      wake_mask_q <= '0;
    end else begin
      wake_q      <= sig_i && (mask_q != '0);
      wake_mask_q <= sig_i ? mask_q : '0;
    end
  end

  assign wake_o      = wake_q;
  assign wake_mask_o = wake_mask_q;

  // R6
  wake_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> mask_q == '0);

  // R6
  mask_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_o |-> wake_mask_o == '0);

  // R6
  wake_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o || $past(sig_i));
endmodule

// File: rtl/sem_resp.sv
module sem_resp
  import sem_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  view_e             view_i,
  input  logic [CNT_W-1:0]  cnt_mid_i,
  input  logic              blk_set_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              block_o
);
  logic [DATA_W-1:0] data_d, data_q;
  logic              valid_q, block_q;

  always_comb begin
    data_d = '0;
    unique case (view_i)
      VIEW_CTL: data_d[TAG_EMPTY_BIT] = (cnt_mid_i == '0);
      default:  data_d = DATA_W'(cnt_mid_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      block_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_req_i;
      block_q <= blk_set_i;
      data_q  <= rd_req_i ? data_d : '0;
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;
  assign block_o    = block_q;

  // R4
  block_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |-> rd_data_o == '0);

  // R4
  block_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |-> rd_valid_o);
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_THR  = 8,
  parameter int unsigned THR_W  = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic [1:0]        rd_view_i,
  input  logic [THR_W-1:0]  rd_thread_i,
  input  logic              wr_req_i,
  input  logic [1:0]        wr_view_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              block_o,
  output logic              wake_o,
  output logic [N_THR-1:0]  wake_mask_o
);
  view_e            rd_view, wr_view;
  logic             sig, wait_rd, blk_set;
  logic [CNT_W-1:0] cnt, cnt_mid;
  logic             unused_wr_data;

  assign rd_view        = view_e'(rd_view_i);
  assign wr_view        = view_e'(wr_view_i);
  assign unused_wr_data = ^{wr_data_i, cnt};

  // bypass and control writes are discarded
  assign sig     = wr_req_i && (wr_view == VIEW_BLK || wr_view == VIEW_TRY);
  assign wait_rd = rd_req_i && (rd_view == VIEW_BLK || rd_view == VIEW_TRY);
  assign blk_set = rd_req_i && (rd_view == VIEW_BLK) && (cnt_mid == '0);

  sem_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sig_i     (sig),
    .wait_i    (wait_rd),
    .cnt_o     (cnt),
    .cnt_mid_o (cnt_mid)
  );

  sem_wait_set #(.N_THR(N_THR), .THR_W(THR_W)) u_wset (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sig_i       (sig),
    .blk_set_i   (blk_set),
    .thread_i    (rd_thread_i),
    .wake_o      (wake_o),
    .wake_mask_o (wake_mask_o)
  );

  sem_resp #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_req_i   (rd_req_i),
    .view_i     (rd_view),
    .cnt_mid_i  (cnt_mid),
    .blk_set_i  (blk_set),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .block_o    (block_o)
  );

  // R10
  no_block_on_sig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig && rd_req_i) |=> !block_o);

  // R2
  resp_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_valid_o);
endmodule

// File: tb/tb_sem_cell.sv
module tb_sem_cell;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned N_THR  = 8;
  localparam int unsigned THR_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rd_req = 1'b0;
  logic [1:0]        rd_view = 2'b00;
  logic [THR_W-1:0]  rd_thr = '0;
  logic              wr_req = 1'b0;
  logic [1:0]        wr_view = 2'b00;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_valid, blk, wake;
  logic [DATA_W-1:0] rd_data;
  logic [N_THR-1:0]  wake_mask;

  int vecs = 0;
  int miscmp = 0;
  bit done = 1'b0;

  // model state
  int               m_cnt = 0;
  logic [N_THR-1:0] m_set = '0;

  always #2.5 clk = ~clk;

  sem_cell dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_req_i(rd_req), .rd_view_i(rd_view), .rd_thread_i(rd_thr),
    .wr_req_i(wr_req), .wr_view_i(wr_view), .wr_data_i(wr_data),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .block_o(blk),
    .wake_o(wake), .wake_mask_o(wake_mask)
  );

  task automatic cmp(input string tag, input logic ev, input logic [DATA_W-1:0] ed,
                     input logic eb, input logic ew, input logic [N_THR-1:0] em);
    vecs++;
    if (rd_valid !== ev || rd_data !== ed || blk !== eb || wake !== ew || wake_mask !== em) begin
      miscmp++;
      $display("FAIL %s: got v=%0b d=%h b=%0b w=%0b m=%h exp v=%0b d=%h b=%0b w=%0b m=%h",
               tag, rd_valid, rd_data, blk, wake, wake_mask, ev, ed, eb, ew, em);
    end
  endtask

  // drive one cycle, update model, compare at the next negedge
  task automatic step(input bit rd, input logic [1:0] rv, input int thr,
                      input bit wr, input logic [1:0] wv, input logic [DATA_W-1:0] d,
                      input string tag);
    logic ev, eb, ew;
    logic [DATA_W-1:0] ed;
    logic [N_THR-1:0] em;
    int mid;
    bit sig, wt;
    rd_req = rd; rd_view = rv; rd_thr = THR_W'(thr);
    wr_req = wr; wr_view = wv; wr_data = d;
    sig = wr && wv[1];
    wt  = rd && rv[1];
    mid = (sig && m_cnt < 65535) ? m_cnt + 1 : m_cnt;
    ev = rd; eb = 1'b0; ed = '0;
    ew = sig && (m_set != 0);
    em = sig ? m_set : '0;
    if (sig) m_set = '0;
    if (rd) begin
      if (rv == 2'b01) ed = (mid == 0) ? 32'd1 : 32'd0;
      else             ed = DATA_W'(mid);
    end
    if (wt && mid == 0 && rv == 2'b10) begin
      eb = 1'b1;
      m_set[thr] = 1'b1;
    end
    if (wt && mid > 0) mid = mid - 1;
    m_cnt = mid;
    @(posedge clk);
    @(negedge clk);
    cmp(tag, ev, ed, eb, ew, em);
  endtask

  task automatic idle(input string tag);
    step(0, 2'b00, 0, 0, 2'b00, '0, tag);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscmp++;
      vecs++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, miscmp);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    cmp("R1", 1'b0, '0, 1'b0, 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1", 1'b0, '0, 1'b0, 1'b0, '0);
    step(1, 2'b00, 0, 0, 2'b00, '0, "R1");       // bypass reads 0
    step(1, 2'b01, 0, 0, 2'b00, '0, "R9");       // tag empty bit
    step(1, 2'b11, 2, 0, 2'b00, '0, "R4");       // try on zero
    step(1, 2'b10, 3, 0, 2'b00, '0, "R4");       // block thread 3
    step(1, 2'b10, 5, 0, 2'b00, '0, "R4");       // block thread 5
    step(0, 2'b00, 0, 1, 2'b00, 32'h1234, "R8"); // bypass write
    step(0, 2'b00, 0, 1, 2'b01, 32'hFFFF, "R8"); // control write
    step(1, 2'b00, 0, 0, 2'b00, '0, "R8");
    step(0, 2'b00, 0, 1, 2'b10, 32'hDEAD, "R6"); // wake 0x28
    idle("R6");
    step(1, 2'b01, 0, 0, 2'b00, '0, "R9");
    step(0, 2'b00, 0, 1, 2'b11, 32'h5, "R7");    // try signal, no wake
    step(1, 2'b11, 0, 0, 2'b00, '0, "R2");       // returns 2
    step(1, 2'b10, 1, 0, 2'b00, '0, "R3");       // returns 1
    step(1, 2'b11, 1, 0, 2'b00, '0, "R3");       // returns 0, stays 0
    step(1, 2'b00, 0, 0, 2'b00, '0, "R3");
    step(1, 2'b10, 1, 1, 2'b11, '0, "R10");      // same cycle, signal first
    step(1, 2'b00, 0, 0, 2'b00, '0, "R10");
    step(1, 2'b10, 0, 0, 2'b00, '0, "R4");       // block thread 0
    step(1, 2'b11, 4, 1, 2'b10, '0, "R10");      // wake + try wait
    step(1, 2'b10, 7, 0, 2'b00, '0, "R4");
    step(0, 2'b00, 0, 1, 2'b11, '0, "R7");       // try signal wakes 0x80
    step(1, 2'b11, 0, 0, 2'b00, '0, "R7");
    for (int i = 0; i < 65536; i++) step(0, 2'b00, 0, 1, 2'b10, DATA_W'(i), "R5");
    step(1, 2'b00, 0, 0, 2'b00, '0, "R5");       // 0xFFFF
    step(0, 2'b00, 0, 1, 2'b11, '0, "R5");
    step(1, 2'b01, 0, 0, 2'b00, '0, "R9");
    step(1, 2'b10, 2, 0, 2'b00, '0, "R5");       // returns 0xFFFF
    step(1, 2'b10, 2, 1, 2'b10, '0, "R10");      // returns 0xFFFF again
    step(1, 2'b00, 0, 0, 2'b00, '0, "R5");
    // drain and random mix
    for (int i = 0; i < 70000 && m_cnt > 0; i++) step(1, 2'b11, 0, 0, 2'b00, '0, "R3");
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 55, 2'($urandom_range(0, 3)), $urandom_range(0, N_THR - 1),
           r > 40, 2'($urandom_range(0, 3)), $urandom, "R2");
    end
    idle("R6");
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miscmp);
    $finish;
  end
endmodule